// File: doc/BRIEF.md
# Dual Threshold and Rate-of-Change Alarm

This block watches two alarm channels against a shared set of sample buses. Seven sample sources (supply voltage, X and Y acceleration, temperature, X and Y incline, rotation) arrive as 14-bit parallel buses, each in a raw and a pre-filtered version, together with a common one-cycle sample strobe. Each channel picks one source, or none, and picks its raw or filtered version. It then compares either the sample itself or its mean sample-to-sample change against a signed threshold. The threshold carries its own greater-than or less-than selection.

A channel that fires sets a sticky status bit in a 16-bit status word. Reading the word (a one-cycle read strobe) clears the bits. A bit that is cleared sets again at the next sample if its condition still holds. An optional indicator drives one of two output lines with a programmable active level. That line is active while either status bit is set.

Top module: `dual_alarm`

## Requirements
- R1: Source select code 0 disables a channel, so it never raises its status bit. Codes 1..7 select supply, X accel, Y accel, temperature, X incline, Y incline and rotation. Code k reads bits [(k-1)*14 +: 14] of the raw or filtered source bus.
- R2: Control word fields are: channel 2 rate enable bit 15, channel 2 source bits 14:12, channel 1 rate enable bit 11, channel 1 source bits 10:8, channel 2 filter select bit 5, channel 1 filter select bit 4. The two channels act independently.
- R3: In a threshold word, bit 15 = 1 means the alarm fires when the compared value is strictly greater than the threshold, and 0 means strictly less than. Bits 13:0 are the threshold. For supply and temperature sources, bits 11:0 of both sample and threshold are taken as unsigned and zero-extended. For all other sources, the 14-bit sample and threshold are two's complement and sign-extended.
- R4: When a channel's filter select bit is 1 it uses the filtered bus, otherwise the raw bus.
- R5: In rate mode the compared value is (current sample − the sample N strobes earlier) / N, in signed arithmetic truncating toward zero. N is the 8-bit count, and counts 0 and 1 both mean 1. The channel keeps a history of its selected sample at every strobe. It cannot fire until at least N earlier samples exist since reset.
- R6: A firing channel sets its status bit at the clock edge that takes the strobe. Channel 1 appears at status bit 8 and channel 2 at bit 9. All other status bits read 0. Without a strobe or a read, the status holds.
- R7: A read strobe clears both status bits at the next edge. If a strobe with a firing condition arrives in the same cycle, the bit is set instead.
- R8: In the control word, bit 2 enables the indicator, bit 1 sets its polarity (1 = active high) and bit 0 selects the line (1 = line 1, 0 = line 0). The selected line is driven, and it is at its active level while either status bit is set. The other line sits at the inactive level.
- R9: With the indicator disabled, neither line is driven and both sit at the inactive level given by bit 1.
- R10: After reset the status bits are 0 and the rate history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | One-cycle strobe: all source buses hold a new sample |
| src_raw | input | 98 | Seven 14-bit unfiltered sources, code k at [(k-1)*14 +: 14] |
| src_filt | input | 98 | Seven 14-bit filtered sources, same layout |
| alarm_ctrl | input | 16 | Channel and indicator control word |
| thr_a | input | 16 | Channel 1 threshold word |
| thr_b | input | 16 | Channel 2 threshold word |
| rate_cnt_a | input | 8 | Channel 1 rate window N |
| rate_cnt_b | input | 8 | Channel 2 rate window N |
| status_rd | input | 1 | Status read strobe, clears the alarm bits |
| status_word | output | 16 | Status word, alarm bits at 8 and 9 |
| dio_level | output | 2 | Indicator levels for the two lines |
| dio_drive | output | 2 | Which line the indicator drives |

## Verification
The checker assumes that the control, threshold and count words do not change in a cycle that carries a sample strobe. It also assumes that the strobe and the read are single-cycle pulses sampled at the rising edge. The bench changes configuration only on idle falling edges between strobes. It pulses the strobe and the read for exactly one cycle. It derives every expected status and indicator value from a reference model that keeps its own per-channel sample history.

// File: rtl/alarm_pkg.sv
// Shared constants, source codes and the sample widening rule for the alarm block.
package alarm_pkg;
    localparam int SRC_W    = 14;       // width of one source bus
    localparam int NSRC     = 7;        // number of selectable sources
    localparam int CODE_W   = 3;        // width of a source select code
    localparam int NARROW_W = 12;       // width of the unsigned sources
    localparam int VAL_W    = SRC_W + 1; // widened signed sample width
    localparam int WORD_W   = 16;       // control / threshold / status word width

    typedef enum logic [CODE_W-1:0] {
        SRC_OFF    = 3'd0,
        SRC_SUPPLY = 3'd1,
        SRC_XACC   = 3'd2,
        SRC_YACC   = 3'd3,
        SRC_TEMP   = 3'd4,
        SRC_XTILT  = 3'd5,
        SRC_YTILT  = 3'd6,
        SRC_ROT    = 3'd7
    } src_code_e;

    // Widen a 14-bit field to a signed value per the selected source's format.
    function automatic logic signed [VAL_W-1:0] widen(input logic [CODE_W-1:0] code,
                                                      input logic [SRC_W-1:0]  field);
        if (code == SRC_SUPPLY || code == SRC_TEMP)
            return $signed({{(VAL_W-NARROW_W){1'b0}}, field[NARROW_W-1:0]});
        else
            return $signed({field[SRC_W-1], field});
    endfunction
endpackage

// File: rtl/alarm_src_mux.sv
// Source selection for one channel: picks raw or filtered bus by code and widens
// both the sample and the threshold magnitude into the common signed format.
// Assumes code 0 selects nothing; the sample then reads as zero.
module alarm_src_mux
    import alarm_pkg::*;
#(
    parameter int SW = SRC_W,
    parameter int NS = NSRC
) (
    input  logic [CODE_W-1:0]        code_i,
    input  logic                     use_filt_i,
    input  logic [NS*SW-1:0]         src_raw_i,
    input  logic [NS*SW-1:0]         src_filt_i,
    input  logic [SW-1:0]            thr_mag_i,
    output logic signed [SW:0]       val_o,
    output logic signed [SW:0]       thr_o
);
    logic [NS*SW-1:0] bus;
    logic [SW-1:0]    pick;

    // Choose the raw or the filtered set of buses.
    assign bus = use_filt_i ? src_filt_i : src_raw_i;

    // Extract the field addressed by the source code.
    always_comb begin
        pick = '0;
        for (int k = 0; k < NS; k++) begin
            if (code_i == CODE_W'(k + 1))
                pick = bus[k*SW +: SW];
        end
    end

    // Apply the source format to both sample and threshold.
    assign val_o = widen(code_i, pick);
    assign thr_o = widen(code_i, thr_mag_i);
endmodule

// File: rtl/alarm_rate.sv
// Sliding history of one channel's selected sample and the mean change over N
// strobes. Writes one entry per strobe into a circular buffer; ready once at
// least N earlier samples are stored. Assumes the window count is stable
// while a strobe is applied.
module alarm_rate #(
    parameter int VW = 15,
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb_i,
    input  logic signed [VW-1:0] val_i,
    input  logic [CW-1:0]        cnt_i,
    output logic signed [VW:0]   mean_o,
    output logic                 ready_o
);
    localparam int DEPTH = 2 ** CW;
    localparam logic [CW-1:0] FILL_MAX = '1;

    logic signed [VW-1:0] hist_mem [DEPTH];
    logic [CW-1:0]        wr_ptr, fill, span, rd_ptr;
    logic signed [VW-1:0] old_val;
    logic signed [VW:0]   diff, divisor;

    // Window length: counts 0 and 1 both mean a single step.
    assign span    = (cnt_i <= CW'(1)) ? CW'(1) : cnt_i;
    assign rd_ptr  = wr_ptr - span;
    assign old_val = hist_mem[rd_ptr];
    assign ready_o = (fill >= span);
    assign diff    = {val_i[VW-1], val_i} - {old_val[VW-1], old_val};
    assign divisor = $signed({{(VW+1-CW){1'b0}}, span});
    assign mean_o  = diff / divisor;

    // Advance the write pointer and the saturating fill count per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else if (stb_i) begin
            wr_ptr <= wr_ptr + CW'(1);
            if (fill != FILL_MAX)
                fill <= fill + CW'(1);
        end
    end

    // Store the current sample into the history buffer.
    always_ff @(posedge clk) begin
        if (stb_i)
            hist_mem[wr_ptr] <= val_i;
    end
endmodule

// File: rtl/alarm_channel.sv
// One alarm channel: source selection, optional rate-of-change path and the
// signed strict comparison against the threshold. Produces a combinational
// hit for the current sample; the caller qualifies it with the strobe.
module alarm_channel
    import alarm_pkg::*;
#(
    parameter int SW = SRC_W,
    parameter int NS = NSRC,
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              use_filt_i,
    input  logic              rate_en_i,
    input  logic              gt_i,
    input  logic [SW-1:0]     thr_mag_i,
    input  logic [CW-1:0]     cnt_i,
    input  logic [NS*SW-1:0]  src_raw_i,
    input  logic [NS*SW-1:0]  src_filt_i,
    output logic              hit_o
);
    logic signed [SW:0]   val, thr;
    logic signed [SW+1:0] mean, cmp_val, thr_w;
    logic                 ready, pass;

    alarm_src_mux #(.SW(SW), .NS(NS)) u_mux (
        .code_i     (code_i),
        .use_filt_i (use_filt_i),
        .src_raw_i  (src_raw_i),
        .src_filt_i (src_filt_i),
        .thr_mag_i  (thr_mag_i),
        .val_o      (val),
        .thr_o      (thr)
    );

    alarm_rate #(.VW(SW+1), .CW(CW)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (stb_i),
        .val_i   (val),
        .cnt_i   (cnt_i),
        .mean_o  (mean),
        .ready_o (ready)
    );

    // Pick the compared quantity and compare strictly in the chosen direction.
    assign cmp_val = rate_en_i ? mean : {val[SW], val};
    assign thr_w   = {thr[SW], thr};
    assign pass    = gt_i ? (cmp_val > thr_w) : (cmp_val < thr_w);
    assign hit_o   = (code_i != SRC_OFF) && (!rate_en_i || ready) && pass;
endmodule

// File: rtl/dual_alarm.sv
// Two independent alarm channels, a clear-on-read status word and an
// indicator that drives one of two lines. Assumes configuration is steady
// around a sample strobe; strobe and read are single-cycle pulses.
module dual_alarm
    import alarm_pkg::*;
#(
    parameter int SW       = SRC_W,
    parameter int NS       = NSRC,
    parameter int CW       = 8,
    parameter int STAT_LSB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_stb,
    input  logic [NS*SW-1:0] src_raw,
    input  logic [NS*SW-1:0] src_filt,
    input  logic [15:0]      alarm_ctrl,
    input  logic [15:0]      thr_a,
    input  logic [15:0]      thr_b,
    input  logic [CW-1:0]    rate_cnt_a,
    input  logic [CW-1:0]    rate_cnt_b,
    input  logic             status_rd,
    output logic [15:0]      status_word,
    output logic [1:0]       dio_level,
    output logic [1:0]       dio_drive
);
    localparam int NCH       = 2;
    localparam int NLINE     = 2;
    localparam int IND_EN    = 2;
    localparam int IND_POL   = 1;
    localparam int IND_SEL   = 0;
    localparam int THR_GT    = 15;

    logic [15:0]   thr_arr [NCH];
    logic [CW-1:0] cnt_arr [NCH];
    logic [NCH-1:0] hit, st_q;
    logic          ind_active;
    logic          unused_bits;

    assign thr_arr[0] = thr_a;
    assign thr_arr[1] = thr_b;
    assign cnt_arr[0] = rate_cnt_a;
    assign cnt_arr[1] = rate_cnt_b;
    assign unused_bits = ^{alarm_ctrl[7:6], alarm_ctrl[3], thr_a[14], thr_b[14]};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int RATE_BIT = 11 + 4 * ch;
        localparam int SRC_LSB  = 8 + 4 * ch;
        localparam int FILT_BIT = 4 + ch;

        alarm_channel #(.SW(SW), .NS(NS), .CW(CW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .stb_i      (sample_stb),
            .code_i     (alarm_ctrl[SRC_LSB +: CODE_W]),
            .use_filt_i (alarm_ctrl[FILT_BIT]),
            .rate_en_i  (alarm_ctrl[RATE_BIT]),
            .gt_i       (thr_arr[ch][THR_GT]),
            .thr_mag_i  (thr_arr[ch][SW-1:0]),
            .cnt_i      (cnt_arr[ch]),
            .src_raw_i  (src_raw),
            .src_filt_i (src_filt),
            .hit_o      (hit[ch])
        );

        // Sticky status bit: a firing sample sets it, a read clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                st_q[ch] <= 1'b0;
            else if (sample_stb && hit[ch])
                st_q[ch] <= 1'b1;
            else if (status_rd)
                st_q[ch] <= 1'b0;
        end
    end

    // Place the alarm bits in the status word; other bits read zero.
    always_comb begin
        status_word = '0;
        status_word[STAT_LSB +: NCH] = st_q;
    end

    assign ind_active = alarm_ctrl[IND_EN] && (|st_q);

    // Indicator: drive the selected line, hold the others at the inactive level.
    always_comb begin
        for (int j = 0; j < NLINE; j++) begin
            dio_drive[j] = alarm_ctrl[IND_EN] && (alarm_ctrl[IND_SEL] == j[0]);
            dio_level[j] = (dio_drive[j] && ind_active) ? alarm_ctrl[IND_POL]
                                                        : ~alarm_ctrl[IND_POL];
        end
    end
endmodule

// File: rtl/alarm_checker.sv
// Temporal checks on the alarm block's ports, bound to every dual_alarm.
module alarm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sample_stb,
    input logic        status_rd,
    input logic [15:0] alarm_ctrl,
    input logic [15:0] status_word,
    input logic [1:0]  dio_level,
    input logic [1:0]  dio_drive
);
    // R7: a read without a strobe leaves both alarm bits clear.
    assert_rd_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !sample_stb) |=> (status_word == 16'h0000));

    // R6: with neither strobe nor read, the status word holds.
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_rd && !sample_stb) |=> $stable(status_word));

    // R6: an alarm bit only rises at the edge that took a strobe.
    assert_rise_on_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status_word[8]) || $rose(status_word[9])) |-> $past(sample_stb));

    // R6: bits outside the alarm field stay zero.
    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word & 16'hFCFF) == 16'h0000);

    // R1: a disabled channel 1 never raises its bit.
    assert_off_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && alarm_ctrl[10:8] == 3'd0 && !status_word[8]) |=> !status_word[8]);

    // R8: at most one line is driven.
    assert_one_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dio_drive));

    // R9: a disabled indicator drives nothing and rests at the inactive level.
    assert_ind_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_ctrl[2] |-> (dio_drive == 2'b00 && dio_level == {2{~alarm_ctrl[1]}}));
endmodule

bind dual_alarm alarm_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_stb  (sample_stb),
    .status_rd   (status_rd),
    .alarm_ctrl  (alarm_ctrl),
    .status_word (status_word),
    .dio_level   (dio_level),
    .dio_drive   (dio_drive)
);

// File: tb/sim_dual_alarm.sv
// Scoreboard bench: driver tasks update a reference model and queue the
// expected outputs; a monitor pops and compares after each clock edge.
module sim_dual_alarm;
    localparam int SW = 14;
    localparam int NS = 7;

    logic clk = 1'b0, rst_n = 1'b0, sample_stb = 1'b0, status_rd = 1'b0;
    logic [SW-1:0] raw_v [NS];
    logic [SW-1:0] filt_v [NS];
    logic [NS*SW-1:0] src_raw, src_filt;
    logic [15:0] alarm_ctrl = '0, thr_a = '0, thr_b = '0;
    logic [7:0]  cnt_a = '0, cnt_b = '0;
    logic [15:0] status_word;
    logic [1:0]  dio_level, dio_drive;

    always #4 clk = ~clk;

    for (genvar k = 0; k < NS; k++) begin : g_pack
        assign src_raw[k*SW +: SW]  = raw_v[k];
        assign src_filt[k*SW +: SW] = filt_v[k];
    end

    dual_alarm u0 (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .src_raw(src_raw), .src_filt(src_filt), .alarm_ctrl(alarm_ctrl),
        .thr_a(thr_a), .thr_b(thr_b), .rate_cnt_a(cnt_a), .rate_cnt_b(cnt_b),
        .status_rd(status_rd), .status_word(status_word),
        .dio_level(dio_level), .dio_drive(dio_drive)
    );

    typedef struct {
        logic [15:0] st;
        logic [1:0]  lvl;
        logic [1:0]  drv;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0, errors = 0;
    int   hist_m [2][$];
    bit   st_m [2];

    // Sample format from R3: supply/temperature unsigned 12-bit, others signed 14-bit.
    function automatic int fmt(int code, logic [13:0] v);
        if (code == 1 || code == 4) return int'(v[11:0]);
        return int'($signed(v));
    endfunction

    function automatic exp_t expect_now(string tag);
        exp_t e;
        bit en, pol, act;
        en  = alarm_ctrl[2];
        pol = alarm_ctrl[1];
        act = en && (st_m[0] || st_m[1]);
        e.st = 16'h0000;
        e.st[8] = st_m[0];
        e.st[9] = st_m[1];
        for (int j = 0; j < 2; j++) begin
            e.drv[j] = en && (int'(alarm_ctrl[0]) == j);
            e.lvl[j] = (e.drv[j] && act) ? pol : !pol;
        end
        e.tag = tag;
        return e;
    endfunction

    task automatic compare(exp_t e);
        checks++;
        if (status_word !== e.st || dio_level !== e.lvl || dio_drive !== e.drv) begin
            errors++;
            $display("FAIL %s: status=%h lvl=%b drv=%b expected status=%h lvl=%b drv=%b",
                     e.tag, status_word, dio_level, dio_drive, e.st, e.lvl, e.drv);
        end
    endtask

    // Driver: one strobe (optionally with a read), model updated per R1-R7.
    task automatic sample_op(bit rd, string tag);
        @(negedge clk);
        sample_stb = 1'b1;
        status_rd  = rd;
        for (int ch = 0; ch < 2; ch++) begin
            int code, x, cmpv, t, n;
            bit rate, gt, hit;
            logic [15:0] thr;
            code = int'(alarm_ctrl[8 + 4*ch +: 3]);
            rate = alarm_ctrl[11 + 4*ch];
            thr  = (ch == 0) ? thr_a : thr_b;
            n    = (ch == 0) ? int'(cnt_a) : int'(cnt_b);
            if (n <= 1) n = 1;
            gt   = thr[15];
            x    = 0;
            if (code != 0)
                x = fmt(code, alarm_ctrl[4 + ch] ? filt_v[code-1] : raw_v[code-1]);
            t    = (code != 0) ? fmt(code, thr[13:0]) : 0;
            hit  = 1'b0;
            if (code != 0) begin
                if (!rate) begin
                    cmpv = x;
                    hit  = gt ? (cmpv > t) : (cmpv < t);
                end else if (hist_m[ch].size() >= n) begin
                    cmpv = (x - hist_m[ch][hist_m[ch].size() - n]) / n;
                    hit  = gt ? (cmpv > t) : (cmpv < t);
                end
            end
            hist_m[ch].push_back(x);
            if (hit) st_m[ch] = 1'b1;
            else if (rd) st_m[ch] = 1'b0;
        end
        q.push_back(expect_now(tag));
        @(negedge clk);
        sample_stb = 1'b0;
        status_rd  = 1'b0;
    endtask

    task automatic read_op(string tag);
        @(negedge clk);
        status_rd = 1'b1;
        st_m[0] = 1'b0;
        st_m[1] = 1'b0;
        q.push_back(expect_now(tag));
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    task automatic direct_check(string tag);
        #1;
        compare(expect_now(tag));
    endtask

    // Monitor: pop the item queued before this edge and compare after it settles.
    initial begin
        forever begin
            @(posedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                #2;
                compare(e);
            end
        end
    end

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < NS; k++) begin
            raw_v[k]  = '0;
            filt_v[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        direct_check("R10 reset state");

        // R5: channel 2 rate on Y accel, N=3, fires only with 3 earlier samples.
        alarm_ctrl = 16'hB000; cnt_b = 8'd3; thr_b = 16'h8000 | 16'h3F9C;
        raw_v[2] = 14'd0;  sample_op(0, "R5 not ready 1");
        raw_v[2] = 14'd5;  sample_op(0, "R5 not ready 2");
        raw_v[2] = 14'd10; sample_op(0, "R5 not ready 3");
        raw_v[2] = 14'd15; sample_op(0, "R5 ready fires");
        read_op("R7 read clears");

        // R3/R6/R7: channel 1 level mode on X accel, greater than 100.
        alarm_ctrl = 16'h0200; thr_a = 16'h8000 | 16'd100;
        raw_v[1] = 14'd50;  sample_op(0, "R3 below threshold");
        raw_v[1] = 14'd100; sample_op(0, "R3 equal is not strict");
        raw_v[1] = 14'd200; sample_op(0, "R6 sets bit 8");
        read_op("R7 read clears bit 8");
        sample_op(0, "R7 persists and sets again");
        sample_op(1, "R7 set wins over read");
        raw_v[1] = 14'd50;  sample_op(1, "R7 read with quiet sample");

        // R3/R2: channel 2 less than -50 on Y incline (signed).
        alarm_ctrl = 16'h6000; thr_b = 16'h3FCE;
        raw_v[5] = 14'h3F9C; sample_op(0, "R3 signed less-than");
        read_op("R7 clear");

        // R3: supply is unsigned 12-bit; bits 13:12 ignored.
        alarm_ctrl = 16'h0100; thr_a = 16'h8000 | 16'h3800;
        raw_v[0] = 14'h37FF; sample_op(0, "R3 unsigned below");
        raw_v[0] = 14'h3900; sample_op(0, "R3 unsigned above");
        read_op("R7 clear");

        // R4: filtered versus raw bus.
        alarm_ctrl = 16'h0210; thr_a = 16'h8000 | 16'd100;
        raw_v[1] = 14'd200; filt_v[1] = 14'd50;  sample_op(0, "R4 filtered quiet");
        raw_v[1] = 14'd50;  filt_v[1] = 14'd200; sample_op(0, "R4 filtered fires");
        read_op("R7 clear");

        // R1: disabled channels never fire.
        alarm_ctrl = 16'h0000; thr_a = 16'h1FFF; thr_b = 16'h1FFF;
        sample_op(0, "R1 disabled silent");

        // R5: channel 1 rate on X accel.
        alarm_ctrl = 16'h0A00; cnt_a = 8'd4; thr_a = 16'h8000 | 16'd10;
        raw_v[1] = 14'd0;
        for (int i = 0; i < 4; i++) sample_op(0, "R5 flat history");
        raw_v[1] = 14'd80; sample_op(0, "R5 mean over 4");
        read_op("R7 clear");
        cnt_a = 8'd0; thr_a = 16'h3FFD;
        raw_v[1] = 14'd10; sample_op(0, "R5 count 0 step");
        raw_v[1] = 14'd3;  sample_op(0, "R5 count 0 is 1");
        read_op("R7 clear");
        cnt_a = 8'd2;
        raw_v[1] = 14'd10; sample_op(0, "R5 window fill");
        raw_v[1] = 14'd0;  sample_op(0, "R5 window fill");
        raw_v[1] = 14'd3;  sample_op(0, "R5 truncation toward zero");

        // R8/R9: indicator.
        read_op("R7 clear");
        alarm_ctrl = 16'h0207; thr_a = 16'h8000 | 16'd100;
        raw_v[1] = 14'd200; sample_op(0, "R8 active high on line 1");
        alarm_ctrl = 16'h0204; direct_check("R8 active low on line 0");
        alarm_ctrl = 16'h0202; direct_check("R9 disabled inactive");
        read_op("R9 clear");
        alarm_ctrl = 16'h0207; direct_check("R8 inactive when clear");

        // R2: both channels fire together.
        alarm_ctrl = 16'h3200; thr_b = 16'h8000 | 16'd100;
        raw_v[2] = 14'd200; sample_op(0, "R2 both channels");

        repeat (3) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule